// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides, for every received CAN frame, whether the frame is taken into the receive FIFO and whether a receive mailbox claims it. The frame identifier, its IDE and RTR flags and a one-cycle valid strobe come from the bit-level receiver. Two searches run in parallel on the same frame. The first compares it against a programmable filter table. The second compares it against the identifiers held in the receive mailboxes. One cycle after the strobe, the block reports the winning filter entry and the winning mailbox.

The filter table is a bank of 32-bit words with a matching bank of mask words. A format selector sets how the table is read: as full extended entries, as pairs of standard entries, or as four 8-bit identifier slices per word. Each entry has a mask at the same bit position in the mask bank. Each mailbox has its own code, identifier word and mask. A mailbox is skipped if it is not an active receive mailbox, or if the CPU is writing its control word during the strobe.

Frame word used for all comparisons: bit 31 is RTR, bit 30 is IDE, bit 29 is 0 and bits 28:0 hold the identifier. An extended frame places `rx_id[28:0]` there. A standard frame places `rx_id[10:0]` in bits 28:18 and zeros below. The "base ID" is bits 28:18 of this word.

Top module: `can_id_filter`

## Requirements
- R1: After reset, all outputs are 0. `res_vld` pulses exactly one cycle after each `frm_vld` cycle. `fifo_hit`, `fifo_idx`, `mb_hit` and `mb_idx` are valid only in that cycle and are 0 at all other times.
- R2: `flt_fmt`=0 (extended) gives 8 entries. Entry w is table word w, using the frame word layout. The entry compares RTR, IDE and the 29 identifier bits.
- R3: `flt_fmt`=1 (standard) gives 16 entries. Entry 2w is bits 31:16 of word w, and entry 2w+1 is bits 15:0. Within each half, bit 15 is RTR, bit 14 is IDE and bits 10:0 are compared with the base ID. Bits 13:11 are ignored.
- R4: `flt_fmt`=2 (slices) gives 32 entries. Entry 4w+k is byte 3-k of word w, so entry 4w is bits 31:24. Each slice compares only bits 10:3 of the base ID. IDE and RTR are ignored.
- R5: A mask bit of 0 makes the corresponding entry bit a don't-care. The mask for an entry sits at the same position in `flt_msk`.
- R6: `flt_fmt`=3 accepts no frame into the FIFO.
- R7: When several filter entries match, `fifo_idx` reports the lowest matching index.
- R8: Mailbox i matches when its word `mb_id[32i+:32]` (frame word layout) equals the frame word on every bit where `mb_msk[32i+:32]` is 1. Bit 29 is ignored. This lets one mailbox take a range of identifiers.
- R9: Only mailboxes whose 4-bit code has bit 3 = 0 and is not 0000 take part. Code 0000 (inactive) and transmit codes (1xxx) never hit.
- R10: A mailbox whose `mb_cs_wr` bit is 1 in the strobe cycle is left out of that match run.
- R11: When several mailboxes match, `mb_idx` reports the lowest index.
- R12: FIFO acceptance and mailbox matching are independent. Both may hit for the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_vld | input | 1 | Received frame strobe, one cycle |
| rx_id | input | 29 | Received identifier (standard in bits 10:0) |
| rx_ide | input | 1 | Frame is extended |
| rx_rtr | input | 1 | Frame is a remote request |
| flt_fmt | input | 2 | Table format: 0 extended, 1 standard, 2 slices, 3 none |
| flt_tbl | input | 32*TBL_WORDS | Filter table words |
| flt_msk | input | 32*TBL_WORDS | Per-entry mask words |
| mb_code | input | 4*NUM_MB | Mailbox codes |
| mb_id | input | 32*NUM_MB | Mailbox identifier words |
| mb_msk | input | 32*NUM_MB | Mailbox masks |
| mb_cs_wr | input | NUM_MB | CPU writing mailbox control word |
| res_vld | output | 1 | Result strobe |
| fifo_hit | output | 1 | Frame accepted by the filter table |
| fifo_idx | output | $clog2(4*TBL_WORDS) | Winning filter entry |
| mb_hit | output | 1 | A mailbox matched |
| mb_idx | output | $clog2(NUM_MB) | Winning mailbox |

## Verification
The hardest case to reach from the ports is the one where the CPU's write lock and the code filter together leave only a higher-index mailbox eligible, even though lower-index mailboxes would otherwise match. The bench programs several mailboxes with the same identifier. It then walks one lower-index mailbox through code 0000, a transmit code and an active receive code. After that it raises the write strobe on one and then two mailboxes in the strobe cycle, so that the winner moves and finally disappears. Index priority in the filter table gets the same treatment: some masks are opened to all don't-cares while the others stay exact.

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int TBL_WORDS = 8,
  parameter int NUM_MB    = 8,
  localparam int FI_W = $clog2(4*TBL_WORDS),
  localparam int MI_W = $clog2(NUM_MB)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_vld,
  input  logic [28:0]             rx_id,
  input  logic                    rx_ide,
  input  logic                    rx_rtr,
  input  logic [1:0]              flt_fmt,
  input  logic [32*TBL_WORDS-1:0] flt_tbl,
  input  logic [32*TBL_WORDS-1:0] flt_msk,
  input  logic [4*NUM_MB-1:0]     mb_code,
  input  logic [32*NUM_MB-1:0]    mb_id,
  input  logic [32*NUM_MB-1:0]    mb_msk,
  input  logic [NUM_MB-1:0]       mb_cs_wr,
  output logic                    res_vld,
  output logic                    fifo_hit,
  output logic [FI_W-1:0]         fifo_idx,
  output logic                    mb_hit,
  output logic [MI_W-1:0]         mb_idx
);

  localparam int N_EXT = TBL_WORDS;
  localparam int N_STD = 2*TBL_WORDS;
  localparam int N_SLC = 4*TBL_WORDS;

  logic [31:0] fw;
  logic [15:0] fh;
  logic        f_hit, m_hit;
  logic [FI_W-1:0] f_idx;
  logic [MI_W-1:0] m_idx;

  assign fw = {rx_rtr, rx_ide, 1'b0, rx_ide ? rx_id : {rx_id[10:0], 18'b0}};
  assign fh = {rx_rtr, rx_ide, 3'b000, fw[28:18]};

  function automatic logic eq32(input logic [31:0] a, input logic [31:0] m, input logic [31:0] f);
    return ((a ^ f) & m & 32'hDFFF_FFFF) == 32'h0;
  endfunction

  function automatic logic eq16(input logic [15:0] a, input logic [15:0] m, input logic [15:0] f);
    return ((a ^ f) & m & 16'hC7FF) == 16'h0;
  endfunction

  function automatic logic eq8(input logic [7:0] a, input logic [7:0] m, input logic [7:0] f);
    return ((a ^ f) & m) == 8'h0;
  endfunction

  always_comb begin
    f_hit = 1'b0;
    f_idx = '0;
    for (int e = N_SLC-1; e >= 0; e--) begin
      logic hit;
      hit = 1'b0;
      case (flt_fmt)
        2'd0: if (e < N_EXT)
                hit = eq32(flt_tbl[e*32 +: 32], flt_msk[e*32 +: 32], fw);
        2'd1: if (e < N_STD)
                hit = eq16(flt_tbl[(e/2)*32 + ((e%2 == 0) ? 16 : 0) +: 16],
                           flt_msk[(e/2)*32 + ((e%2 == 0) ? 16 : 0) +: 16], fh);
        2'd2: hit = eq8(flt_tbl[(e/4)*32 + (3 - e%4)*8 +: 8],
                        flt_msk[(e/4)*32 + (3 - e%4)*8 +: 8], fw[28:21]);
        default: hit = 1'b0;
      endcase
      if (hit) begin
        f_hit = 1'b1;
        f_idx = FI_W'(e);
      end
    end
  end

  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    for (int i = NUM_MB-1; i >= 0; i--) begin
      logic [3:0] code;
      code = mb_code[i*4 +: 4];
      if (!code[3] && code != 4'b0000 && !mb_cs_wr[i] &&
          eq32(mb_id[i*32 +: 32], mb_msk[i*32 +: 32], fw)) begin
        m_hit = 1'b1;
        m_idx = MI_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      fifo_hit <= 1'b0;
      fifo_idx <= '0;
      mb_hit   <= 1'b0;
      mb_idx   <= '0;
    end else begin
      res_vld  <= frm_vld;
      fifo_hit <= frm_vld & f_hit;
      fifo_idx <= frm_vld ? f_idx : '0;
      mb_hit   <= frm_vld & m_hit;
      mb_idx   <= frm_vld ? m_idx : '0;
    end
  end

endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int TBL_WORDS = 8,
  parameter int NUM_MB    = 8,
  localparam int FI_W = $clog2(4*TBL_WORDS),
  localparam int MI_W = $clog2(NUM_MB)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frm_vld,
  input logic [1:0]          flt_fmt,
  input logic [4*NUM_MB-1:0] mb_code,
  input logic [NUM_MB-1:0]   mb_cs_wr,
  input logic                res_vld,
  input logic                fifo_hit,
  input logic [FI_W-1:0]     fifo_idx,
  input logic                mb_hit,
  input logic [MI_W-1:0]     mb_idx
);

  logic [4*NUM_MB-1:0] code_q;
  logic [NUM_MB-1:0]   cs_q;
  logic [1:0]          fmt_q;
  logic [3:0]          sel_code;
  logic                sel_cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cs_q   <= '0;
      fmt_q  <= 2'd3;
    end else begin
      code_q <= mb_code;
      cs_q   <= mb_cs_wr;
      fmt_q  <= flt_fmt;
    end
  end

  always_comb begin
    sel_code = code_q[int'(mb_idx)*4 +: 4];
    sel_cs   = cs_q[int'(mb_idx)];
  end

  p_res_after_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(frm_vld));
  p_fifo_only_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_hit |-> res_vld);
  p_mb_only_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mb_hit |-> res_vld);
  p_ext_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_hit && fmt_q == 2'd0) |-> (int'(fifo_idx) < TBL_WORDS));
  p_std_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_hit && fmt_q == 2'd1) |-> (int'(fifo_idx) < 2*TBL_WORDS));
  p_no_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == 2'd3) |-> !fifo_hit);
  p_mb_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mb_hit |-> (!sel_code[3] && sel_code != 4'b0000));
  p_mb_not_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mb_hit |-> !sel_cs);

endmodule

bind can_id_filter can_id_filter_chk #(.TBL_WORDS(TBL_WORDS), .NUM_MB(NUM_MB)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .flt_fmt(flt_fmt),
  .mb_code(mb_code), .mb_cs_wr(mb_cs_wr), .res_vld(res_vld),
  .fifo_hit(fifo_hit), .fifo_idx(fifo_idx), .mb_hit(mb_hit), .mb_idx(mb_idx)
);

// File: tb/test_can_id_filter.sv
`timescale 1ns/1ps
module test_can_id_filter;
  localparam int TW = 8;
  localparam int NM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_vld = 1'b0;
  logic [28:0] rx_id = '0;
  logic rx_ide = 1'b0, rx_rtr = 1'b0;
  logic [1:0] flt_fmt = 2'd0;
  logic [32*TW-1:0] flt_tbl = '0, flt_msk = '0;
  logic [4*NM-1:0] mb_code = '0;
  logic [32*NM-1:0] mb_id = '0, mb_msk = '0;
  logic [NM-1:0] mb_cs_wr = '0;
  logic res_vld, fifo_hit, mb_hit;
  logic [4:0] fifo_idx;
  logic [2:0] mb_idx;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_id_filter #(.TBL_WORDS(TW), .NUM_MB(NM)) i_can_id_filter (.*);

  task automatic chk(input string req, input logic fh, input int fi, input logic mh, input int mi);
    checks++;
    if (res_vld !== 1'b1 || fifo_hit !== fh || (fh && int'(fifo_idx) != fi) ||
        mb_hit !== mh || (mh && int'(mb_idx) != mi)) begin
      errors++;
      $display("FAIL %s: got vld=%b fifo=%b/%0d mb=%b/%0d, expected vld=1 fifo=%b/%0d mb=%b/%0d",
               req, res_vld, fifo_hit, fifo_idx, mb_hit, mb_idx, fh, fi, mh, mi);
    end
  endtask

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr);
    @(negedge clk);
    rx_id = id; rx_ide = ide; rx_rtr = rtr; frm_vld = 1'b1;
    @(negedge clk);
    frm_vld = 1'b0;
    #0.5;
  endtask

  task automatic clear_all();
    flt_tbl = '0; flt_msk = '1; mb_code = '0; mb_id = '0; mb_msk = '1; mb_cs_wr = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    checks++;
    if (res_vld !== 0 || fifo_hit !== 0 || fifo_idx !== 0 || mb_hit !== 0 || mb_idx !== 0) begin
      errors++;
      $display("FAIL R1 reset: got %b %b %0d %b %0d, expected all 0", res_vld, fifo_hit, fifo_idx, mb_hit, mb_idx);
    end
    send(29'h0000001, 1'b1, 1'b0);
    @(negedge clk);
    checks++;
    if (res_vld !== 0 || fifo_hit !== 0 || mb_hit !== 0) begin
      errors++;
      $display("FAIL R1 idle: got vld=%b fifo=%b mb=%b, expected 0 0 0", res_vld, fifo_hit, mb_hit);
    end
  endtask

  task automatic t_ext();
    clear_all(); flt_fmt = 2'd0;
    flt_tbl[3*32 +: 32] = {1'b0, 1'b1, 1'b0, 29'h1234567};
    send(29'h1234567, 1'b1, 1'b0); chk("R2 ext exact", 1, 3, 0, 0);
    send(29'h1234568, 1'b1, 1'b0); chk("R2 ext miss", 0, 0, 0, 0);
    send(29'h1234567, 1'b1, 1'b1); chk("R2 ext rtr differs", 0, 0, 0, 0);
    flt_tbl[5*32 +: 32] = {1'b0, 1'b1, 1'b0, 29'h1234560};
    flt_msk[5*32 +: 32] = 32'hDFFF_FFF0;
    send(29'h123456F, 1'b1, 1'b0); chk("R5 mask dont-care", 1, 5, 0, 0);
    send(29'h123457F, 1'b1, 1'b0); chk("R5 masked bit kept", 0, 0, 0, 0);
  endtask

  task automatic t_std();
    clear_all(); flt_fmt = 2'd1;
    flt_tbl[3*32 +: 32] = {16'h0155, 16'h03A5};
    send(29'h00003A5, 1'b0, 1'b0); chk("R3 std lower half", 1, 7, 0, 0);
    send(29'h0000155, 1'b0, 1'b0); chk("R3 std upper half", 1, 6, 0, 0);
    send({11'h3A5, 18'h0}, 1'b1, 1'b0); chk("R3 std ide differs", 0, 0, 0, 0);
  endtask

  task automatic t_slice();
    clear_all(); flt_fmt = 2'd2;
    flt_tbl[3*32 +: 32] = 32'h00AB_0000;
    send(29'h000055D, 1'b0, 1'b0); chk("R4 slice std", 1, 13, 0, 0);
    send(29'h1560_0000, 1'b1, 1'b1); chk("R4 slice ext rtr ignored", 1, 13, 0, 0);
    send(29'h000055D, 1'b0, 1'b1); chk("R4 slice rtr ignored", 1, 13, 0, 0);
  endtask

  task automatic t_fmt3();
    clear_all(); flt_fmt = 2'd3; flt_msk = '0;
    send(29'h0000042, 1'b0, 1'b0); chk("R6 format 3 no accept", 0, 0, 0, 0);
  endtask

  task automatic t_prio();
    clear_all(); flt_fmt = 2'd0; flt_msk = '0;
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R7 all match lowest", 1, 0, 0, 0);
    flt_msk = '1;
    flt_msk[2*32 +: 32] = '0; flt_msk[6*32 +: 32] = '0;
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R7 two match lowest", 1, 2, 0, 0);
  endtask

  task automatic t_mb();
    clear_all(); flt_fmt = 2'd0;
    flt_tbl[0 +: 32] = {1'b0, 1'b1, 1'b0, 29'h0ABCDEF};
    mb_code[4*4 +: 4] = 4'b0100;
    mb_id[4*32 +: 32] = {1'b0, 1'b1, 1'b0, 29'h0ABCDEF};
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R12 fifo and mb together", 1, 0, 1, 4);
    send(29'h0ABCD12, 1'b1, 1'b0); chk("R8 mb exact miss", 0, 0, 0, 0);
    mb_msk[4*32 +: 32] = 32'hDFFF_FF00;
    send(29'h0ABCD12, 1'b1, 1'b0); chk("R8 mb range", 0, 0, 1, 4);
    mb_code[6*4 +: 4] = 4'b0010;
    mb_id[6*32 +: 32] = {1'b0, 1'b0, 1'b0, 11'h123, 18'h0};
    send(29'h0000123, 1'b0, 1'b0); chk("R8 mb standard", 0, 0, 1, 6);
  endtask

  task automatic t_mb_active();
    clear_all(); flt_fmt = 2'd3;
    mb_code[4*4 +: 4] = 4'b0100;
    mb_id[4*32 +: 32] = {1'b0, 1'b1, 1'b0, 29'h0ABCDEF};
    mb_id[2*32 +: 32] = {1'b0, 1'b1, 1'b0, 29'h0ABCDEF};
    mb_code[2*4 +: 4] = 4'b0000;
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R9 inactive skipped", 0, 0, 1, 4);
    mb_code[2*4 +: 4] = 4'b1100;
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R9 transmit skipped", 0, 0, 1, 4);
    mb_code[2*4 +: 4] = 4'b0010;
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R11 lowest mailbox", 0, 0, 1, 2);
    mb_cs_wr[2] = 1'b1;
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R10 locked skipped", 0, 0, 1, 4);
    mb_cs_wr[4] = 1'b1;
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R10 both locked", 0, 0, 0, 0);
    mb_cs_wr = '0;
    send(29'h0ABCDEF, 1'b1, 1'b0); chk("R10 lock released", 0, 0, 1, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ext();
    t_std();
    t_slice();
    t_fmt3();
    t_prio();
    t_mb();
    t_mb_active();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule